// File: doc/BRIEF.md
# Per-Lane Selectable Event Counter

This block watches the event strobes of a multi-lane serial link controller and counts exactly one of them. Three fields in a control word pick what is counted: an event group, an event number inside that group, and a lane. Each strobe bit pulses for one clock cycle whenever its event happens on its lane. When the strobe chosen by the current selection is high and counting is switched on, one shared counter advances by one.

Software drives the block through a plain register port. Each cycle carries at most one write, and reads return data in the same cycle without a clock edge. Counting is switched on and off by a coded command written into the control word. A second coded command zeroes the counter. The counter is never zeroed by itself, so it has to be cleared before a new measurement starts. The count can be read from a data register and is also available on a dedicated output.

Top module: `lane_evt_counter`

## Requirements
- R1: The control word sits at byte offset 0x8 and the count at offset 0xC. Every other offset reads as zero, and a write to offset 0xC leaves the count unchanged.
- R2: In the control word, bits 27:24 hold the group, bits 23:16 hold the event number and bits 11:8 hold the lane. All three read back exactly as written. Bits 31:28, 15:12, 6:0 and the two command fields always read 0.
- R3: Bits 4:2 of a control write carry the enable command. Code 3 starts counting, code 1 stops it, and every other code leaves the counting state unchanged. The new state applies from the clock edge that takes the write.
- R4: Bit 7 of the control word reads 1 exactly while counting is on. Writes to bit 7 have no effect.
- R5: When bits 1:0 of a control write hold code 1, the count becomes 0 at the edge that takes the write. This clear wins over an increment in the same cycle. Other clear codes do nothing, and switching counting on never clears the count.
- R6: A write that carries both the clear code and the stop code leaves the count at 0 with counting off. A write that carries the clear code and the start code counts up from 0 afterwards.
- R7: While counting is on, the count rises by one at each edge where strobe bit ((group*EVT_PER_GRP)+event)*NUM_LANES+lane is high. No other strobe bit has any effect.
- R8: If the group is at least NUM_GROUPS, the event number is at least EVT_PER_GRP, or the lane is at least NUM_LANES, the count never changes, whatever the strobes do.
- R9: The count is CNT_W bits wide (32 by default) and wraps modulo 2^CNT_W.
- R10: After reset, counting is off, the count is 0 and the control word reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| evt_strb | input | NUM_LANES*NUM_GROUPS*EVT_PER_GRP | One strobe per (group, event, lane) |
| count_o | output | 32 | Current count, zero-extended |

## Verification
The hardest situation to reach is a cycle in which a clear command arrives while the selected strobe is high and counting is on. The stimulus raises the strobe on the same falling edge that presents the clearing write, then reads a zero count right after that edge. The bench also wraps the count, which 32 bits cannot do in a short run. For this it uses a second instance with a 4-bit counter and drives it past its modulus. Out-of-range selections are tested with every strobe bit held high, so that any wrong index would show up in the count.

// File: rtl/lec_pkg.sv
package lec_pkg;
   localparam int CTRL_OFS = 8;
   localparam int DATA_OFS = 12;

   localparam logic [2:0] EN_CMD_ON  = 3'd3;
   localparam logic [2:0] EN_CMD_OFF = 3'd1;
   localparam logic [1:0] CLR_CMD_GO = 2'd1;

   typedef struct packed {
      logic [3:0] grp;
      logic [7:0] evn;
      logic [3:0] lane;
   } lec_sel_t;
endpackage

// File: rtl/lec_ctrl_reg.sv
module lec_ctrl_reg
   import lec_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output lec_sel_t          sel,
   output logic              en,
   output logic              clr_pulse,
   output logic [31:0]       ctrl_rd
);
   logic ctrl_wr;
   logic unused_wbits;

   assign ctrl_wr      = wr && (addr == ADDR_W'(CTRL_OFS));
   assign clr_pulse    = ctrl_wr && (wdata[1:0] == CLR_CMD_GO);
   assign unused_wbits = ^{wdata[31:28], wdata[15:12], wdata[7:5]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= '0;
         en  <= 1'b0;
      end else if (ctrl_wr) begin
         sel.grp  <= wdata[27:24];
         sel.evn  <= wdata[23:16];
         sel.lane <= wdata[11:8];
         if (wdata[4:2] == EN_CMD_ON)       en <= 1'b1;
         else if (wdata[4:2] == EN_CMD_OFF) en <= 1'b0;
      end
   end

   assign ctrl_rd = {4'b0, sel.grp, sel.evn, 4'b0, sel.lane, en, 7'b0};
endmodule

// File: rtl/lec_event_mux.sv
module lec_event_mux
   import lec_pkg::*;
#(
   parameter int NUM_LANES   = 4,
   parameter int NUM_GROUPS  = 8,
   parameter int EVT_PER_GRP = 20,
   parameter int HIT_PIPE    = 0,
   localparam int NUM_BITS   = NUM_LANES * NUM_GROUPS * EVT_PER_GRP,
   localparam int IDX_W      = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_BITS-1:0] strb,
   input  lec_sel_t            sel,
   output logic                hit,
   output logic                sel_ok
);
   logic             in_range;
   logic [IDX_W-1:0] idx;
   logic             raw_hit;

   assign in_range = (int'(sel.grp) < NUM_GROUPS) &&
                     (int'(sel.evn) < EVT_PER_GRP) &&
                     (int'(sel.lane) < NUM_LANES);

   always_comb begin
      idx     = IDX_W'((int'(sel.grp) * EVT_PER_GRP + int'(sel.evn)) * NUM_LANES
                       + int'(sel.lane));
      raw_hit = in_range && strb[idx];
   end

   generate
      if (HIT_PIPE == 0) begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign hit    = raw_hit;
         assign sel_ok = in_range;
      end else begin : g_pipe
         logic hit_q, ok_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hit_q <= 1'b0;
               ok_q  <= 1'b0;
            end else begin
               hit_q <= raw_hit;
               ok_q  <= in_range;
            end
         end
         assign hit    = hit_q;
         assign sel_ok = ok_q;
      end
   endgenerate
endmodule

// File: rtl/lec_counter.sv
module lec_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter
   import lec_pkg::*;
#(
   parameter int NUM_LANES   = 4,
   parameter int NUM_GROUPS  = 8,
   parameter int EVT_PER_GRP = 20,
   parameter int CNT_W       = 32,
   parameter int ADDR_W      = 8,
   parameter int HIT_PIPE    = 0,
   localparam int NUM_BITS   = NUM_LANES * NUM_GROUPS * EVT_PER_GRP
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic [NUM_BITS-1:0] evt_strb,
   output logic [31:0]         count_o
);
   initial begin
      if (NUM_LANES < 1 || NUM_LANES > 16)    $error("NUM_LANES must be 1..16");
      if (NUM_GROUPS < 1 || NUM_GROUPS > 16)  $error("NUM_GROUPS must be 1..16");
      if (EVT_PER_GRP < 1 || EVT_PER_GRP > 256) $error("EVT_PER_GRP must be 1..256");
      if (CNT_W < 1 || CNT_W > 32)            $error("CNT_W must be 1..32");
      if (ADDR_W < 4)                         $error("ADDR_W must be at least 4");
      if (HIT_PIPE != 0 && HIT_PIPE != 1)     $error("HIT_PIPE must be 0 or 1");
   end

   lec_sel_t         sel;
   logic             en_q;
   logic             clr_pulse;
   logic [31:0]      ctrl_rd;
   logic             hit;
   logic             sel_ok;
   logic [CNT_W-1:0] count_q;

   lec_ctrl_reg #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .sel(sel), .en(en_q), .clr_pulse(clr_pulse), .ctrl_rd(ctrl_rd)
   );

   lec_event_mux #(
      .NUM_LANES(NUM_LANES), .NUM_GROUPS(NUM_GROUPS),
      .EVT_PER_GRP(EVT_PER_GRP), .HIT_PIPE(HIT_PIPE)
   ) u_mux (
      .clk(clk), .rst_n(rst_n), .strb(evt_strb), .sel(sel),
      .hit(hit), .sel_ok(sel_ok)
   );

   lec_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .inc(en_q && hit), .cnt(count_q)
   );

   assign count_o = 32'(count_q);

   always_comb begin
      if (reg_addr == ADDR_W'(CTRL_OFS))      reg_rdata = ctrl_rd;
      else if (reg_addr == ADDR_W'(DATA_OFS)) reg_rdata = count_o;
      else                                    reg_rdata = '0;
   end
endmodule

// File: rtl/lec_checker.sv
module lec_checker #(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic              en,
   input logic              sel_ok,
   input logic [CNT_W-1:0]  cnt
);
   logic ctl_wr, clr_req;
   logic unused_w;
   assign ctl_wr   = wr && (addr == ADDR_W'(8));
   assign clr_req  = ctl_wr && (wdata[1:0] == 2'd1);
   assign unused_w = ^{wdata[31:5]};

   a_r3_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[4:2] == 3'd3) |=> en);
   a_r3_turn_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[4:2] == 3'd1) |=> !en);
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr_req) |=> $stable(cnt));
   a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> (cnt == '0));
   a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_req |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1))));
   a_r8_no_count_oor: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_ok && !clr_req) |=> $stable(cnt));
endmodule

bind lane_evt_counter lec_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
   .en(en_q), .sel_ok(sel_ok), .cnt(count_q)
);

// File: tb/tb_lane_evt_counter.sv
module tb_lane_evt_counter;
   localparam int LANES = 4, GROUPS = 8, EPG = 20;
   localparam int NB = LANES * GROUPS * EPG;
   localparam logic [7:0] A_CTRL = 8'h08, A_DATA = 8'h0C;

   typedef struct packed {
      logic [3:0] g;
      logic [7:0] e;
      logic [3:0] l;
      logic [7:0] n;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{4'd0, 8'd0,  4'd0, 8'd5},
      '{4'd7, 8'd19, 4'd3, 8'd9},
      '{4'd1, 8'd4,  4'd2, 8'd3},
      '{4'd6, 8'd16, 4'd1, 8'd12},
      '{4'd3, 8'd7,  4'd0, 8'd1},
      '{4'd5, 8'd2,  4'd3, 8'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, count, rdata_w, count_w;
   logic [NB-1:0] strb = '0;
   logic [1:0] strb_w = '0;
   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   lane_evt_counter dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr_en), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .evt_strb(strb), .count_o(count)
   );

   lane_evt_counter #(.NUM_LANES(2), .NUM_GROUPS(1), .EVT_PER_GRP(1), .CNT_W(4)) dut_w (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr_en), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata_w), .evt_strb(strb_w), .count_o(count_w)
   );

   function automatic logic [31:0] cw(input logic [3:0] g, input logic [7:0] e,
                                      input logic [3:0] l, input logic [2:0] en,
                                      input logic [1:0] clr);
      return {4'b0, g, e, 4'b0, l, 3'b0, en, clr};
   endfunction

   function automatic logic [31:0] rb(input logic [3:0] g, input logic [7:0] e,
                                      input logic [3:0] l, input logic st);
      return {4'b0, g, e, 4'b0, l, st, 7'b0};
   endfunction

   function automatic int bit_idx(input int g, input int e, input int l);
      return (g * EPG + e) * LANES + l;
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic hits(input int idx, input int n);
      for (int i = 0; i < n; i++) begin
         strb = '0; strb[idx] = 1'b1;
         @(negedge clk);
      end
      strb = '0;
   endtask

   task automatic noise(input int idx, input int n);
      for (int i = 0; i < n; i++) begin
         strb = '1; strb[idx] = 1'b0;
         @(negedge clk);
      end
      strb = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int ix;
      repeat (3) @(negedge clk);
      // R10: reset state
      rd(A_CTRL, v); chk("R10 ctrl after reset", v, 32'h0);
      rd(A_DATA, v); chk("R10 count after reset", v, 32'h0);
      chk("R10 count_o after reset", count, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: vector table walk
      for (int i = 0; i < 6; i++) begin
         ix = bit_idx(VECS[i].g, VECS[i].e, VECS[i].l);
         wr(A_CTRL, cw(VECS[i].g, VECS[i].e, VECS[i].l, 3'd1, 2'd1));
         wr(A_CTRL, cw(VECS[i].g, VECS[i].e, VECS[i].l, 3'd3, 2'd0));
         noise(ix, 3);
         hits(ix, VECS[i].n);
         noise(ix, 2);
         wr(A_CTRL, cw(VECS[i].g, VECS[i].e, VECS[i].l, 3'd1, 2'd0));
         rd(A_CTRL, v); chk("R2 select readback", v, rb(VECS[i].g, VECS[i].e, VECS[i].l, 1'b0));
         rd(A_DATA, v); chk("R7 selected event count", v, 32'(VECS[i].n));
      end

      // R1: unmapped offset and ignored data write
      rd(8'h04, v); chk("R1 unmapped offset", v, 32'h0);
      wr(A_DATA, 32'h1234_5678);
      rd(A_DATA, v); chk("R1 data write ignored", v, 32'h0);

      // R2/R4: reserved and status bits ignored on write
      wr(A_CTRL, 32'hF000_F0E0 | cw(4'd2, 8'd9, 4'd1, 3'd0, 2'd0));
      rd(A_CTRL, v); chk("R2 reserved bits read zero", v, rb(4'd2, 8'd9, 4'd1, 1'b0));
      chk("R4 status write ignored", {31'b0, v[7]}, 32'h0);

      // R3/R4: enable codes
      ix = bit_idx(0, 0, 0);
      wr(A_CTRL, cw(4'd0, 8'd0, 4'd0, 3'd3, 2'd1));
      rd(A_CTRL, v); chk("R4 status on", v, rb(4'd0, 8'd0, 4'd0, 1'b1));
      wr(A_CTRL, cw(4'd0, 8'd0, 4'd0, 3'd0, 2'd0));
      rd(A_CTRL, v); chk("R3 code 0 keeps on", v, rb(4'd0, 8'd0, 4'd0, 1'b1));
      wr(A_CTRL, cw(4'd0, 8'd0, 4'd0, 3'd2, 2'd0));
      rd(A_CTRL, v); chk("R3 code 2 keeps on", v, rb(4'd0, 8'd0, 4'd0, 1'b1));
      hits(ix, 4);
      wr(A_CTRL, cw(4'd0, 8'd0, 4'd0, 3'd1, 2'd0));
      rd(A_CTRL, v); chk("R4 status off", v, rb(4'd0, 8'd0, 4'd0, 1'b0));
      hits(ix, 3);
      rd(A_DATA, v); chk("R3 stopped holds count", v, 32'd4);

      // R5: no clear on re-enable, other clear codes inert
      wr(A_CTRL, cw(4'd0, 8'd0, 4'd0, 3'd3, 2'd0));
      hits(ix, 3);
      rd(A_DATA, v); chk("R5 enable does not clear", v, 32'd7);
      wr(A_CTRL, cw(4'd0, 8'd0, 4'd0, 3'd0, 2'd2));
      rd(A_DATA, v); chk("R5 clear code 2 inert", v, 32'd7);
      wr(A_CTRL, cw(4'd0, 8'd0, 4'd0, 3'd0, 2'd3));
      rd(A_DATA, v); chk("R5 clear code 3 inert", v, 32'd7);

      // R5: clear wins over a simultaneous increment
      @(negedge clk);
      strb = '0; strb[ix] = 1'b1;
      wr_en = 1'b1; addr = A_CTRL; wdata = cw(4'd0, 8'd0, 4'd0, 3'd0, 2'd1);
      @(negedge clk);
      wr_en = 1'b0; strb = '0;
      rd(A_DATA, v); chk("R5 clear beats increment", v, 32'd0);
      hits(ix, 2);
      rd(A_DATA, v); chk("R5 counting resumes after clear", v, 32'd2);

      // R6: clear with stop, then clear with start
      wr(A_CTRL, cw(4'd0, 8'd0, 4'd0, 3'd1, 2'd1));
      hits(ix, 3);
      rd(A_DATA, v); chk("R6 clear+stop count", v, 32'd0);
      rd(A_CTRL, v); chk("R6 clear+stop status", v, rb(4'd0, 8'd0, 4'd0, 1'b0));
      wr(A_CTRL, cw(4'd0, 8'd0, 4'd0, 3'd3, 2'd1));
      hits(ix, 6);
      rd(A_DATA, v); chk("R6 clear+start counts from zero", v, 32'd6);

      // R8: out-of-range selections with all strobes high
      wr(A_CTRL, cw(4'd0, 8'd0, 4'd4, 3'd3, 2'd1));
      strb = '1; repeat (5) @(negedge clk); strb = '0;
      rd(A_DATA, v); chk("R8 lane out of range", v, 32'd0);
      wr(A_CTRL, cw(4'd1, 8'd20, 4'd0, 3'd3, 2'd1));
      strb = '1; repeat (5) @(negedge clk); strb = '0;
      rd(A_DATA, v); chk("R8 event out of range", v, 32'd0);
      wr(A_CTRL, cw(4'd8, 8'd0, 4'd0, 3'd3, 2'd1));
      strb = '1; repeat (5) @(negedge clk); strb = '0;
      rd(A_DATA, v); chk("R8 group out of range", v, 32'd0);

      // R9: wrap on the 4-bit instance
      wr(A_CTRL, cw(4'd0, 8'd0, 4'd1, 3'd3, 2'd1));
      chk("R9 narrow counter cleared", count_w, 32'd0);
      for (int i = 0; i < 18; i++) begin
         strb_w = 2'b10;
         @(negedge clk);
      end
      strb_w = 2'b00;
      chk("R9 wrap modulo 16", count_w, 32'd2);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule